// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a master on the internal clocked bus read and write an external asynchronous static RAM. The RAM holds 2^18 words of 16 bits and has two byte lanes. The master raises a request together with an address, write data, a lane mask and a direction flag. The controller takes these fields into registers on the cycle it accepts the request. It then drives the memory's chip-select, output-enable, write-strobe and per-lane enables, all active low, and it reports completion with a one-cycle acknowledge. On a read, the read data and a valid strobe come out in the same cycle as the acknowledge.

How long each strobe lasts is worked out when the design is elaborated. The clock period and the memory's timing minimums are parameters, and each window is converted to a whole number of cycles, rounded up, with a floor of one cycle. There are three windows: the write pulse, the read access wait, and the bus release time after a read. The shared data bus is split into an outgoing value, a driver enable and an incoming value. The controller drives the bus only while the write strobe is low, plus one cycle of data hold after it. Every read is followed by a release window in which nothing drives the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after it is released, the chip select, output enable and write strobe outputs are high, both lane enables are high, the bus driver is off, and acknowledge and read-valid are low.
- R2: An accepted write holds the write strobe low for exactly max(1, ceil(T_WP_PS/CLK_PS)) consecutive cycles. During that time chip select is low, output enable is high, the address and data are the ones given at acceptance, and the driver is on. Lane enable bit 0 is low exactly when mask bit 0 is 1 (data bits 7:0), and lane enable bit 1 is low exactly when mask bit 1 is 1 (data bits 15:8).
- R3: The bus driver is on only in cycles where the write strobe is low, or in the one cycle right after the strobe goes back high. In that hold cycle the write strobe is high and the driver is still on.
- R4: A write is acknowledged by a single-cycle pulse in the hold cycle that follows the last write-strobe cycle.
- R5: An accepted read holds chip select and output enable low, with the write strobe high and the driver off, for exactly max(1, ceil(T_ACC_PS/CLK_PS)) cycles. Acknowledge and read-valid then pulse together for one cycle, carrying the word sampled at the end of that window.
- R6: A read returns zero in every byte lane whose mask bit is 0, whatever the memory presents on those pins.
- R7: After a read's acknowledge cycle, a request that is already waiting gets its first strobe cycle no earlier than max(1, ceil(T_TURN_PS/CLK_PS)) cycles later. In those cycles all strobes are high and the driver is off.
- R8: The driver is never on in a cycle where output enable is low.
- R9: Requests are sampled only while the block is idle. Changes to the request fields after acceptance do not affect the access in progress. After a write's acknowledge, a waiting request starts after exactly one idle cycle. With no request, all strobes stay inactive and acknowledge stays low.
- R10: A write with mask 00 keeps both lane enables high, so a later read of that address returns the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Access request, held until acknowledged |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_lane_en | input | LANES | Per-lane enable mask, bit 0 = bits 7:0 |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rvalid | output | 1 | Read data valid, coincides with ack on reads |
| host_rdata | output | DATA_W | Read data, disabled lanes zero |
| ram_addr | output | ADDR_W | Memory address |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_lane_n | output | LANES | Byte lane enables, active low, bit 0 = bits 7:0 |
| ram_dq_out | output | DATA_W | Value for the shared data bus |
| ram_dq_drive | output | 1 | Bus driver enable |
| ram_dq_in | input | DATA_W | Value seen on the shared data bus |

## Verification
The assertions assume that the master deasserts its request in the cycle in which it sees the acknowledge. If it does not, a second access of the same kind would start at once. That would still satisfy the properties, but it would upset the bench's counting. The bench always drops the request at the sampling point of the acknowledge cycle and issues the next request at that same point, so the back-to-back gaps are measured exactly. The memory model drives the bus only while chip select and output enable are low with the write strobe high. It puts a marker byte on disabled lanes and a different pattern when nothing drives the bus, so a controller that passes those bytes through is caught. Before a read, the bench writes only through the controller, and it picks addresses that differ in their low six bits so that the compact model never aliases two of them.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the static RAM controller.
// Assumes all timing figures are given in picoseconds.
package asram_pkg;

    // Sequencer phases; each names what the memory pins show in that phase.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_PULSE = 3'd1,
        ST_WR_HOLD  = 3'd2,
        ST_RD_WAIT  = 3'd3,
        ST_TURN     = 3'd4
    } asram_state_e;

    // Whole clock cycles covering a time span, never fewer than one.
    function automatic int unsigned span_cycles(input int unsigned span_ps,
                                                input int unsigned clk_ps);
        int unsigned n;
        n = (span_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    // Larger of two counts, used to size the shared window counter.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_cycle_timer.sv
`timescale 1ns/1ps
// Down-counter that measures one strobe window.
// A load sets the remaining count; expired is high once the count reaches zero.
// Assumes the sequencer loads N-1 to obtain an N-cycle window.
module asram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count the current window down to zero, or restart it on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Access sequencer: accepts one request while idle and steps through
// the write pulse and hold, or the read wait and bus release.
// Produces the next phase for the pin stage, so that pins are registered.
// Assumes the master drops its request in the cycle it sees acknowledge.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int WP_CYC   = 1,
    parameter int RD_CYC   = 1,
    parameter int TURN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_write,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output asram_state_e     state_d,
    output logic             take,
    output logic             capture,
    output logic             ack,
    output logic             rvalid
);

    asram_state_e state_q;
    logic         finish_wr;

    // Next-phase decision and timer loading for every phase.
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        load_val  = '0;
        take      = 1'b0;
        capture   = 1'b0;
        finish_wr = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    take = 1'b1;
                    load = 1'b1;
                    if (host_write) begin
                        state_d  = ST_WR_PULSE;
                        load_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        state_d  = ST_RD_WAIT;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    state_d   = ST_WR_HOLD;
                    finish_wr = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            ST_RD_WAIT: begin
                if (expired) begin
                    state_d  = ST_TURN;
                    load     = 1'b1;
                    load_val = CNT_W'(TURN_CYC - 1);
                    capture  = 1'b1;
                end
            end
            ST_TURN: begin
                if (expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered completion strobes toward the master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            rvalid <= 1'b0;
        end else begin
            ack    <= finish_wr | capture;
            rvalid <= capture;
        end
    end

endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
// Pin stage: registers every memory control from the sequencer's next phase,
// so the pins change only at clock edges and never glitch on a state decode.
// Latches address, write data and lane mask at acceptance, and captures
// read data per lane, zeroing lanes the mask left out.
module asram_pins
    import asram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asram_state_e      state_d,
    input  logic              take,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_lane_en,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [LANES-1:0]  ram_lane_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_drive,
    output logic [DATA_W-1:0] rd_data
);

    logic [LANES-1:0] lane_q;
    logic [LANES-1:0] lane_sel;
    logic             active_d;

    assign lane_sel = take ? host_lane_en : lane_q;
    assign active_d = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD) ||
                      (state_d == ST_RD_WAIT);

    // Hold the accepted request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q     <= '0;
            ram_addr   <= '0;
            ram_dq_out <= '0;
        end else if (take) begin
            lane_q     <= host_lane_en;
            ram_addr   <= host_addr;
            ram_dq_out <= host_wdata;
        end
    end

    // Strobes and driver enable follow the phase entered at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_cs_n     <= 1'b1;
            ram_oe_n     <= 1'b1;
            ram_we_n     <= 1'b1;
            ram_lane_n   <= '1;
            ram_dq_drive <= 1'b0;
        end else begin
            ram_cs_n     <= !active_d;
            ram_oe_n     <= (state_d != ST_RD_WAIT);
            ram_we_n     <= (state_d != ST_WR_PULSE);
            ram_lane_n   <= active_d ? ~lane_sel : '1;
            ram_dq_drive <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
        end
    end

    // One capture register per byte lane; masked-off lanes read as zero.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data[l*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rd_data[l*LANE_W +: LANE_W] <= lane_q[l] ? ram_dq_in[l*LANE_W +: LANE_W]
                                                         : '0;
            end
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous static RAM controller.
// Converts the memory timing minimums into cycle counts at elaboration,
// and joins the sequencer, the window timer and the pin stage.
// Assumes CLK_PS matches the real clock and the T_* values include board margin.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int LANE_W    = 8,
    parameter int CLK_PS    = 20000,
    parameter int T_WP_PS   = 7000,
    parameter int T_ACC_PS  = 10000,
    parameter int T_TURN_PS = 4000,
    localparam int LANES    = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_lane_en,
    output logic              host_ack,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [LANES-1:0]  ram_lane_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_drive,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int WP_CYC   = span_cycles(T_WP_PS, CLK_PS);
    localparam int RD_CYC   = span_cycles(T_ACC_PS, CLK_PS);
    localparam int TURN_CYC = span_cycles(T_TURN_PS, CLK_PS);
    localparam int MAX_CYC  = max2(max2(WP_CYC, RD_CYC), TURN_CYC);
    localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             take;
    logic             capture;
    asram_state_e     state_d;

    asram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    asram_seq #(
        .CNT_W    (CNT_W),
        .WP_CYC   (WP_CYC),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_write (host_write),
        .expired    (expired),
        .load       (load),
        .load_val   (load_val),
        .state_d    (state_d),
        .take       (take),
        .capture    (capture),
        .ack        (host_ack),
        .rvalid     (host_rvalid)
    );

    asram_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_d      (state_d),
        .take         (take),
        .capture      (capture),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_lane_en (host_lane_en),
        .ram_dq_in    (ram_dq_in),
        .ram_addr     (ram_addr),
        .ram_cs_n     (ram_cs_n),
        .ram_oe_n     (ram_oe_n),
        .ram_we_n     (ram_we_n),
        .ram_lane_n   (ram_lane_n),
        .ram_dq_out   (ram_dq_out),
        .ram_dq_drive (ram_dq_drive),
        .rd_data      (host_rdata)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for asram_ctrl, attached by bind below.
// Assumes the master follows the request/acknowledge rule stated in the brief.
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int CLK_PS  = 20000,
    parameter int T_WP_PS = 7000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic              ram_dq_drive,
    input logic              host_ack,
    input logic              host_rvalid
);

    localparam int WP_CYC = span_cycles(T_WP_PS, CLK_PS);

    int unsigned we_run;

    // Length of the current write-strobe run, in completed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_run <= 0;
        else if (!ram_we_n) we_run <= we_run + 1;
        else                we_run <= 0;
    end

    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_dq_drive && !ram_oe_n));

    // R3
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_drive |-> (!ram_we_n || $past(!ram_we_n)));

    // R2
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_cs_n && ram_oe_n && ram_dq_drive));

    // R2
    write_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (we_run < WP_CYC));

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_addr));

    // R5
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (!ram_cs_n && ram_we_n));

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R5
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (host_ack && $past(!ram_oe_n)));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .CLK_PS  (CLK_PS),
    .T_WP_PS (T_WP_PS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ram_addr     (ram_addr),
    .ram_cs_n     (ram_cs_n),
    .ram_oe_n     (ram_oe_n),
    .ram_we_n     (ram_we_n),
    .ram_dq_drive (ram_dq_drive),
    .host_ack     (host_ack),
    .host_rvalid  (host_rvalid)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a byte-lane memory model on the pins, transaction tasks
// that measure strobe windows and gaps, and a per-clock monitor for bus rules.
module asram_ctrl_tb;

    localparam int CLK_PS  = 20000;
    localparam int WP_PS   = 45000;
    localparam int ACC_PS  = 70000;
    localparam int TURN_PS = 25000;
    localparam int WP_EXP   = (WP_PS + CLK_PS - 1) / CLK_PS;
    localparam int RD_EXP   = (ACC_PS + CLK_PS - 1) / CLK_PS;
    localparam int TURN_EXP = (TURN_PS + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [17:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_lane_en = '0;
    logic        host_ack;
    logic        host_rvalid;
    logic [15:0] host_rdata;
    logic [17:0] ram_addr;
    logic        ram_cs_n, ram_oe_n, ram_we_n, ram_dq_drive;
    logic [1:0]  ram_lane_n;
    logic [15:0] ram_dq_out;
    logic [15:0] ram_dq_in;

    int n_checks = 0;
    int n_err    = 0;

    logic [15:0] mem_a [0:63];
    logic [15:0] ref_mem [int];
    logic [15:0] mem_word;
    logic        prev_we_low = 1'b0;

    always #10 clk = ~clk;

    asram_ctrl #(
        .CLK_PS    (CLK_PS),
        .T_WP_PS   (WP_PS),
        .T_ACC_PS  (ACC_PS),
        .T_TURN_PS (TURN_PS)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_write   (host_write),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_lane_en (host_lane_en),
        .host_ack     (host_ack),
        .host_rvalid  (host_rvalid),
        .host_rdata   (host_rdata),
        .ram_addr     (ram_addr),
        .ram_cs_n     (ram_cs_n),
        .ram_oe_n     (ram_oe_n),
        .ram_we_n     (ram_we_n),
        .ram_lane_n   (ram_lane_n),
        .ram_dq_out   (ram_dq_out),
        .ram_dq_drive (ram_dq_drive),
        .ram_dq_in    (ram_dq_in)
    );

    // Memory model: lane writes while selected with strobe low; reads put
    // marker bytes on disabled lanes and a float pattern when undriven.
    initial for (int i = 0; i < 64; i++) mem_a[i] = 16'h0000;

    always @(posedge clk) begin
        if (rst_n && !ram_cs_n && !ram_we_n && ram_dq_drive) begin
            if (!ram_lane_n[0]) mem_a[ram_addr[5:0]][7:0]  <= ram_dq_out[7:0];
            if (!ram_lane_n[1]) mem_a[ram_addr[5:0]][15:8] <= ram_dq_out[15:8];
        end
    end

    assign mem_word = mem_a[ram_addr[5:0]];

    always_comb begin
        if (ram_dq_drive) begin
            ram_dq_in = ram_dq_out;
        end else if (!ram_cs_n && !ram_oe_n && ram_we_n) begin
            ram_dq_in[7:0]  = ram_lane_n[0] ? 8'h5A : mem_word[7:0];
            ram_dq_in[15:8] = ram_lane_n[1] ? 8'h5A : mem_word[15:8];
        end else begin
            ram_dq_in = 16'hC3C3;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the bus rules (R8 contention, R3 driver window).
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(ram_dq_drive && !ram_oe_n), "R8", {ram_dq_drive, ram_oe_n}, 2'b01);
            check(!ram_dq_drive || !ram_we_n || prev_we_low, "R3",
                  {ram_dq_drive, ram_we_n, prev_we_low}, 3'b010);
            prev_we_low = !ram_we_n;
        end else begin
            prev_we_low = 1'b0;
        end
    end

    function automatic logic [15:0] ref_rd(input logic [17:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    endfunction

    // Checks that every pin shows the idle level.
    task automatic check_quiet(input string tag);
        check(ram_cs_n && ram_oe_n && ram_we_n && ram_lane_n == 2'b11 &&
              !ram_dq_drive && !host_ack && !host_rvalid, tag,
              {ram_cs_n, ram_oe_n, ram_we_n, ram_lane_n, ram_dq_drive, host_ack, host_rvalid},
              8'b11111000);
    endtask

    // Write access; exp_pre = cycles expected before the strobe starts.
    task automatic do_write(input logic [17:0] a, input logic [15:0] d,
                            input logic [1:0] m, input int exp_pre,
                            input bit disturb, input string gap_tag);
        int pre = 0, low = 0, cyc = 0;
        bit seen = 0, bad = 0, got = 0, hold_ok = 0;
        host_req = 1'b1; host_write = 1'b1;
        host_addr = a; host_wdata = d; host_lane_en = m;
        while (!got && cyc < 60) begin
            @(posedge clk); @(negedge clk); cyc++;
            if (!ram_we_n) begin
                seen = 1; low++;
                if (ram_cs_n || !ram_oe_n || ram_addr != a || ram_lane_n != ~m ||
                    !ram_dq_drive || ram_dq_out != d) bad = 1;
                if (disturb) begin
                    host_addr = ~a; host_wdata = ~d; host_lane_en = ~m;
                end
            end else if (!seen) begin
                pre++;
            end
            if (host_ack) begin
                got = 1;
                hold_ok = ram_we_n && ram_dq_drive && !ram_cs_n && ram_dq_out == d;
            end
        end
        host_req = 1'b0;
        check(got, "R4", got, 1);
        check(low == WP_EXP, "R2", low, WP_EXP);
        check(!bad, disturb ? "R9" : "R2", bad, 0);
        check(hold_ok, "R3", hold_ok, 1);
        check(pre == exp_pre, gap_tag, pre, exp_pre);
        if (m[0]) ref_mem[int'(a)] = {ref_rd(a)[15:8], d[7:0]};
        if (m[1]) ref_mem[int'(a)] = {d[15:8], ref_rd(a)[7:0]};
    endtask

    // Read access; checks window length, lane pins and returned word.
    task automatic do_read(input logic [17:0] a, input logic [1:0] m,
                           input int exp_pre, input string gap_tag, input string data_tag);
        int pre = 0, low = 0, cyc = 0;
        bit seen = 0, bad = 0, got = 0, rv = 0;
        logic [15:0] got_d = '0, exp_d;
        exp_d = ref_rd(a) & {{8{m[1]}}, {8{m[0]}}};
        host_req = 1'b1; host_write = 1'b0; host_addr = a; host_lane_en = m;
        host_wdata = 16'hFFFF;
        while (!got && cyc < 60) begin
            @(posedge clk); @(negedge clk); cyc++;
            if (!ram_oe_n) begin
                seen = 1; low++;
                if (ram_cs_n || !ram_we_n || ram_dq_drive || ram_addr != a ||
                    ram_lane_n != ~m) bad = 1;
            end else if (!seen) begin
                pre++;
            end
            if (host_ack) begin
                got = 1; rv = host_rvalid; got_d = host_rdata;
            end
        end
        host_req = 1'b0;
        check(got && rv, "R5", {got, rv}, 2'b11);
        check(low == RD_EXP, "R5", low, RD_EXP);
        check(!bad, "R5", bad, 0);
        check(got_d == exp_d, data_tag, got_d, exp_d);
        check(pre == exp_pre, gap_tag, pre, exp_pre);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R1");                       // R1 in reset
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");                       // R1 first cycle after release
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); check_quiet("R9");   // R9 no request, pins idle
        end

        do_write(18'h12345, 16'hBEEF, 2'b11, 0, 0, "R9");
        repeat (2) @(negedge clk);
        do_read(18'h12345, 2'b11, 0, "R9", "R5");
        do_write(18'h12345, 16'h1122, 2'b01, TURN_EXP, 0, "R7");   // R7 read->write gap
        do_read(18'h12345, 2'b11, 1, "R9", "R2");                   // lower lane only
        do_write(18'h12345, 16'h3344, 2'b10, TURN_EXP, 0, "R7");
        do_read(18'h12345, 2'b01, 1, "R9", "R6");                   // R6 upper zeroed
        do_read(18'h12345, 2'b10, TURN_EXP, "R7", "R6");            // R6 lower zeroed
        do_write(18'h12345, 16'hFFFF, 2'b00, TURN_EXP, 0, "R7");
        do_read(18'h12345, 2'b11, 1, "R9", "R10");                  // R10 unchanged
        do_write(18'h3FFFF, 16'hA5C3, 2'b11, TURN_EXP, 1, "R7");    // R9 disturbed fields
        do_read(18'h3FFFF, 2'b11, 1, "R9", "R9");
        do_read(18'h00000, 2'b11, TURN_EXP, "R7", "R5");
        do_write(18'h2A0AA, 16'h0F0F, 2'b11, TURN_EXP, 0, "R7");
        do_write(18'h00011, 16'h7E81, 2'b11, 1, 0, "R9");          // write->write gap
        do_read(18'h2A0AA, 2'b11, 1, "R9", "R5");
        do_read(18'h00011, 2'b11, TURN_EXP, "R7", "R5");
        do_read(18'h12345, 2'b11, TURN_EXP, "R7", "R10");

        repeat (TURN_EXP) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); check_quiet("R9");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule